// File: doc/BRIEF.md
# Strided Vector Address Generator

This block turns a vector layout into a stream of byte addresses for a memory streaming unit. A layout is made of a base byte address, a signed element stride, an element count per run, a signed element skip, an element precision (single or double) and a target flag that picks main memory or the local scratchpad. The scratchpad has its own address space, which starts at zero.

A start pulse loads the layout together with a separate total element count for the operation. From the next cycle on, the block offers one address per cycle over a valid/ready handshake. Inside a run the address moves by the scaled stride. After each full run it moves by the scaled stride plus the scaled skip, and a new run begins. The final address carries a last marker, and after it the block is idle again. A layout whose run count is zero is rejected with an error pulse and produces no addresses.

Top module: `vag_addr_gen`

## Requirements
- R1: After reset `addr_valid_o`, `last_o` and `err_o` are all 0.
- R2: A start accepted while idle makes `addr_valid_o` 1 on the next cycle, with `addr_o` equal to `base_i` and `scratch_o` equal to the `scratch_i` value sampled at the start.
- R3: Inside a run, each next address equals the previous address plus stride×4 for single precision (`dbl_i`=0) or plus stride×8 for double precision (`dbl_i`=1).
- R4: After the address that completes a run of `count_i` elements, the next address equals that address plus (stride+skip)×element size.
- R5: Stride and skip are two's-complement values, so negative values move the address down, with wrap modulo 2^AW.
- R6: When `lay_en_i` is 0, the block uses stride 1, count 1 and skip 0, whatever `stride_i`, `count_i` and `skip_i` hold.
- R7: Exactly `total_i` addresses are handed over, whatever the value of `count_i`. `last_o` is 1 on the final one and on no other, and `addr_valid_o` falls on the cycle after the final handshake.
- R8: A start with `lay_en_i`=1 and `count_i`=0 sets `err_o` to 1 for exactly the next cycle and produces no address.
- R9: While `addr_valid_o` is 1 and `addr_ready_i` is 0, `addr_o`, `last_o` and `scratch_o` hold their values.
- R10: A start pulse while addresses are still being issued is ignored, and the current stream continues unchanged.
- R11: A start with `total_i`=0 and a valid layout produces no address and no error, and the block stays idle.
- R12: With `addr_ready_i` held at 1, one address is handed over on every cycle until the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| base_i | input | AW | Byte address of the first element |
| stride_i | input | FW | Signed element stride |
| count_i | input | FW | Elements per run |
| skip_i | input | FW | Signed element skip between runs |
| lay_en_i | input | 1 | 1: use the layout fields; 0: use the defaults 1/1/0 |
| dbl_i | input | 1 | 1: 8-byte elements; 0: 4-byte elements |
| scratch_i | input | 1 | 1: scratchpad target; 0: main memory |
| total_i | input | TW | Number of addresses to generate |
| addr_ready_i | input | 1 | Consumer accepts the current address |
| addr_valid_o | output | 1 | Address offered |
| addr_o | output | AW | Byte address |
| scratch_o | output | 1 | Target space of the current stream |
| last_o | output | 1 | Current address is the final one |
| err_o | output | 1 | One-cycle pulse for a zero run count |

## Verification
Two things can land in the same cycle: the run-boundary jump and back-pressure. The stalled scenario uses a run count of 3 and toggles ready every cycle, so several skip jumps fall on stalled cycles. The bench requires the held address to stay put while ready is low and the jump to be applied exactly once when the handshake completes. A start pulse that arrives during a live stream, including the stream's first cycles, is judged by the address sequence continuing unchanged from the first layout.

// File: rtl/vag_pkg.sv
package vag_pkg;
    localparam int DEF_STRIDE = 1;
    localparam int DEF_COUNT  = 1;
    localparam int DEF_SKIP   = 0;

    typedef enum logic [1:0] {
        SH_SINGLE = 2'd2,
        SH_DOUBLE = 2'd3
    } elem_shift_e;
endpackage

// File: rtl/vag_cfg_sel.sv
module vag_cfg_sel #(
    parameter int FW = 16
) (
    input  logic          lay_en_i,
    input  logic [FW-1:0] stride_i,
    input  logic [FW-1:0] count_i,
    input  logic [FW-1:0] skip_i,
    output logic [FW-1:0] stride_o,
    output logic [FW-1:0] count_o,
    output logic [FW-1:0] skip_o
);
    import vag_pkg::*;

    always_comb begin
        if (lay_en_i) begin
            stride_o = stride_i;
            count_o  = count_i;
            skip_o   = skip_i;
        end else begin
            stride_o = FW'(DEF_STRIDE);
            count_o  = FW'(DEF_COUNT);
            skip_o   = FW'(DEF_SKIP);
        end
    end
endmodule

// File: rtl/vag_scale.sv
module vag_scale #(
    parameter int FW = 16,
    parameter int AW = 32
) (
    input  logic [FW-1:0] elem_i,
    input  logic          dbl_i,
    output logic [AW-1:0] bytes_o
);
    import vag_pkg::*;

    logic [AW-1:0] ext;
    elem_shift_e   sh;

    always_comb begin
        ext     = {{(AW-FW){elem_i[FW-1]}}, elem_i};
        sh      = dbl_i ? SH_DOUBLE : SH_SINGLE;
        bytes_o = ext << sh;
    end
endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen #(
    parameter int AW = 32,
    parameter int FW = 16,
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [FW-1:0] stride_i,
    input  logic [FW-1:0] count_i,
    input  logic [FW-1:0] skip_i,
    input  logic          lay_en_i,
    input  logic          dbl_i,
    input  logic          scratch_i,
    input  logic [TW-1:0] total_i,
    input  logic          addr_ready_i,
    output logic          addr_valid_o,
    output logic [AW-1:0] addr_o,
    output logic          scratch_o,
    output logic          last_o,
    output logic          err_o
);
    typedef struct packed {
        logic          busy;
        logic          err;
        logic          scratch;
        logic [AW-1:0] addr;
        logic [AW-1:0] step_b;
        logic [AW-1:0] skip_b;
        logic [TW-1:0] rem;
        logic [FW-1:0] pos;
        logic [FW-1:0] cnt;
    } state_t;

    state_t q, d;

    logic [FW-1:0] sel_stride, sel_count, sel_skip;
    logic [AW-1:0] stride_bytes, skip_bytes;

    vag_cfg_sel #(.FW(FW)) u_sel (
        .lay_en_i (lay_en_i),
        .stride_i (stride_i),
        .count_i  (count_i),
        .skip_i   (skip_i),
        .stride_o (sel_stride),
        .count_o  (sel_count),
        .skip_o   (sel_skip)
    );

    vag_scale #(.FW(FW), .AW(AW)) u_scale_stride (
        .elem_i  (sel_stride),
        .dbl_i   (dbl_i),
        .bytes_o (stride_bytes)
    );

    vag_scale #(.FW(FW), .AW(AW)) u_scale_skip (
        .elem_i  (sel_skip),
        .dbl_i   (dbl_i),
        .bytes_o (skip_bytes)
    );

    always_comb begin
        d     = q;
        d.err = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                if (sel_count == '0) begin
                    d.err = 1'b1;
                end else if (total_i != '0) begin
                    d.busy    = 1'b1;
                    d.addr    = base_i;
                    d.rem     = total_i;
                    d.pos     = '0;
                    d.cnt     = sel_count;
                    d.step_b  = stride_bytes;
                    d.skip_b  = skip_bytes;
                    d.scratch = scratch_i;
                end
            end
        end else if (addr_ready_i) begin
            if (q.rem == TW'(1)) begin
                d.busy = 1'b0;
            end else begin
                d.rem = q.rem - TW'(1);
                if (q.pos == q.cnt - FW'(1)) begin
                    d.pos  = '0;
                    d.addr = q.addr + q.step_b + q.skip_b;
                end else begin
                    d.pos  = q.pos + FW'(1);
                    d.addr = q.addr + q.step_b;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign addr_valid_o = q.busy;
    assign addr_o       = q.addr;
    assign scratch_o    = q.scratch;
    assign last_o       = q.busy && (q.rem == TW'(1));
    assign err_o        = q.err;
endmodule

// File: rtl/vag_addr_gen_chk.sv
module vag_addr_gen_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          addr_valid_o,
    input logic          addr_ready_i,
    input logic [AW-1:0] addr_o,
    input logic          scratch_o,
    input logic          last_o,
    input logic          err_o
);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && !addr_ready_i) |=>
            (addr_valid_o && $stable(addr_o) && $stable(last_o) && $stable(scratch_o)));

    p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> addr_valid_o);

    p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && last_o) |=> !addr_valid_o);

    p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !addr_valid_o);

    p_rate_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid_o && addr_ready_i && !last_o) |=> addr_valid_o);
endmodule

bind vag_addr_gen vag_addr_gen_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .addr_o       (addr_o),
    .scratch_o    (scratch_o),
    .last_o       (last_o),
    .err_o        (err_o)
);

// File: tb/vag_addr_gen_bench.sv
module vag_addr_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int FW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [FW-1:0] stride_i = '0;
    logic [FW-1:0] count_i = '0;
    logic [FW-1:0] skip_i = '0;
    logic          lay_en_i = 1'b0;
    logic          dbl_i = 1'b0;
    logic          scratch_i = 1'b0;
    logic [TW-1:0] total_i = '0;
    logic          addr_ready_i = 1'b0;
    logic          addr_valid_o;
    logic [AW-1:0] addr_o;
    logic          scratch_o;
    logic          last_o;
    logic          err_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vag_addr_gen #(.AW(AW), .FW(FW), .TW(TW)) u_vag_addr_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .stride_i(stride_i), .count_i(count_i), .skip_i(skip_i),
        .lay_en_i(lay_en_i), .dbl_i(dbl_i), .scratch_i(scratch_i),
        .total_i(total_i), .addr_ready_i(addr_ready_i),
        .addr_valid_o(addr_valid_o), .addr_o(addr_o), .scratch_o(scratch_o),
        .last_o(last_o), .err_o(err_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 valid", 64'(addr_valid_o), 64'd0);
        check("R1 last", 64'(last_o), 64'd0);
        check("R1 err", 64'(err_o), 64'd0);
    endtask

    // generic stream: stall 1 toggles ready, intrude 1 pulses start mid-stream
    task automatic t_stream(input string tag, input logic [AW-1:0] base, input int stride,
                            input int cnt, input int skip, input bit dbl, input bit scr,
                            input bit lay, input int total, input bit stall, input bit intrude);
        logic [AW-1:0] ea;
        logic [AW-1:0] held;
        bit   holding;
        int   k, pos, cyc, sz, ecnt, estr, eskp;
        sz   = dbl ? 8 : 4;
        ecnt = lay ? cnt : 1;
        estr = lay ? stride : 1;
        eskp = lay ? skip : 0;
        @(negedge clk);
        base_i = base; stride_i = FW'(stride); count_i = FW'(cnt); skip_i = FW'(skip);
        dbl_i = dbl; scratch_i = scr; lay_en_i = lay; total_i = TW'(total);
        start_i = 1'b1;
        @(negedge clk);
        start_i = intrude;
        if (intrude) begin
            base_i = 32'hDEAD_0000; total_i = TW'(3);
        end
        check({tag, " R2 first valid"}, 64'(addr_valid_o), 64'd1);
        check({tag, " R2 first addr"}, 64'(addr_o), 64'(base));
        check({tag, " R2 scratch"}, 64'(scratch_o), 64'(scr));
        ea = base; k = 0; pos = 0; cyc = 0; holding = 1'b0;
        while (k < total && cyc < 1000) begin
            if (intrude && cyc == 4) start_i = 1'b0;
            addr_ready_i = stall ? cyc[0] : 1'b1;
            if (holding) begin
                check({tag, " R9 held addr"}, 64'(addr_o), 64'(held));
                holding = 1'b0;
            end
            if (addr_valid_o && addr_ready_i) begin
                check({tag, " R3 R4 R5 addr"}, 64'(addr_o), 64'(ea));
                check({tag, " R7 last"}, 64'(last_o), 64'(k == total - 1));
                pos++;
                if (pos == ecnt) begin
                    pos = 0;
                    ea = ea + AW'((estr + eskp) * sz);
                end else begin
                    ea = ea + AW'(estr * sz);
                end
                k++;
            end else if (addr_valid_o) begin
                held = addr_o; holding = 1'b1;
            end else begin
                check({tag, " R7 valid dropped early"}, 64'(addr_valid_o), 64'd1);
            end
            cyc++;
            @(negedge clk);
        end
        start_i = 1'b0;
        addr_ready_i = 1'b0;
        check({tag, " R7 count"}, 64'(k), 64'(total));
        if (!stall) check({tag, " R12 cycles"}, 64'(cyc), 64'(total));
        check({tag, " R7 idle after"}, 64'(addr_valid_o), 64'd0);
        @(negedge clk);
        check({tag, " R10 no restart"}, 64'(addr_valid_o), 64'd0);
    endtask

    task automatic t_zero_count();
        @(negedge clk);
        lay_en_i = 1'b1; count_i = '0; total_i = TW'(5); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8 err pulse", 64'(err_o), 64'd1);
        check("R8 no valid", 64'(addr_valid_o), 64'd0);
        @(negedge clk);
        check("R8 err clears", 64'(err_o), 64'd0);
        check("R8 still idle", 64'(addr_valid_o), 64'd0);
    endtask

    task automatic t_zero_total();
        @(negedge clk);
        lay_en_i = 1'b1; count_i = FW'(2); total_i = '0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R11 no valid", 64'(addr_valid_o), 64'd0);
        check("R11 no err", 64'(err_o), 64'd0);
        @(negedge clk);
        check("R11 idle", 64'(addr_valid_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stream("single", 32'h0000_1000, 2, 3, 1, 1'b0, 1'b0, 1'b1, 8, 1'b0, 1'b0);
        t_stream("double neg R5", 32'h0000_0100, -1, 2, -3, 1'b1, 1'b1, 1'b1, 6, 1'b0, 1'b0);
        t_stream("wrap R5", 32'h0000_0008, -2, 4, 0, 1'b0, 1'b1, 1'b1, 5, 1'b0, 1'b0);
        t_stream("defaults R6", 32'h0000_2000, 7, 0, 9, 1'b1, 1'b0, 1'b0, 4, 1'b0, 1'b0);
        t_stream("stall R9", 32'h0000_4000, 1, 3, 5, 1'b1, 1'b0, 1'b1, 9, 1'b1, 1'b0);
        t_stream("busy start R10", 32'h0000_8000, 3, 2, 2, 1'b0, 1'b1, 1'b1, 7, 1'b0, 1'b1);
        t_stream("long run R7", 32'h0000_0040, 1, 100, 4, 1'b0, 1'b0, 1'b1, 3, 1'b0, 1'b0);
        t_zero_count();
        t_zero_total();
        t_stream("after err", 32'h0000_0200, 1, 1, 1, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule